// File: doc/BRIEF.md
# Prioritized Exception Vector Generator

This block gathers every exception request a CPU core can see: three classes of reset, an illegal-instruction trap, a software interrupt or debug entry, an X-maskable request, an external IRQ line and a bank of I-maskable peripheral interrupt lines. Each time the CPU pulses its vector-fetch strobe, the block ranks these requests by a fixed priority and captures a 16-bit vector address. It holds that address until the next strobe.

Reset vectors are fixed addresses at the top of the map. All other vectors take their upper byte from a writable base register and their lower byte from a per-source offset, so software can move the whole table. The requests are sampled again on the strobe cycle itself. A request that was seen as pending but was dropped before the CPU fetched its vector therefore produces the spurious vector and not a stale one. A combinational pending output tells the CPU that some unmasked non-reset request is active.

Top module: `excvec_gen`

## Requirements
- R1: After reset, `vec_addr` reads 0xFFFE and the base register holds 0xFF, so a spurious fetch with no other write returns 0xFF80.
- R2: On a fetch, any reset request wins over everything else, whatever the masks or base hold. `rst_por` gives 0xFFFE, then `rst_clkmon` gives 0xFFFC, then `rst_wdog` gives 0xFFFA, in that order of precedence.
- R3: With no reset requested, the order is `trap_req` (low byte 0xF8), then `swi_req` (0xF6), then `xreq` (0xF4), then `irq_req` (0xF2). The upper byte is the base register.
- R4: Peripheral line n (bit n of `per_req`) maps to low byte 0xF0 - 2n. The lowest pending n wins. Every peripheral line ranks below `irq_req`.
- R5: `x_mask`=1 blocks `xreq`. `i_mask`=1 blocks `irq_req` and all peripheral lines. The trap and software requests cannot be masked.
- R6: A fetch with no unmasked request active in the strobe cycle yields {base, 0x80}. This includes a request that was pending earlier and was withdrawn before the strobe.
- R7: `int_pending` is 1 in the same cycle that any unmasked non-reset request is active, and 0 otherwise.
- R8: `vec_addr` changes only on the clock edge at which `vec_req` is 1. At every other edge it holds its value, even while requests change.
- R9: `base_wr`=1 loads `base_wdata` into the base register at the clock edge. Fetches at later edges use the new upper byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rst_por | input | 1 | Pin, power-on, illegal-address or low-voltage reset request |
| rst_clkmon | input | 1 | Clock-monitor reset request |
| rst_wdog | input | 1 | Watchdog reset request |
| trap_req | input | 1 | Unimplemented-opcode trap request |
| swi_req | input | 1 | Software interrupt or debug entry request |
| xreq | input | 1 | X-maskable interrupt request |
| irq_req | input | 1 | External IRQ request |
| per_req | input | N_PERIPH | Peripheral interrupt lines, bit 0 highest priority |
| x_mask | input | 1 | Mask for `xreq` |
| i_mask | input | 1 | Mask for `irq_req` and `per_req` |
| base_wr | input | 1 | Base register write enable |
| base_wdata | input | 8 | Base register write data |
| vec_req | input | 1 | Vector-fetch strobe from the CPU |
| int_pending | output | 1 | Any unmasked non-reset request active |
| vec_addr | output | 16 | Captured vector address |

## Verification
The bench raises several requests together at each priority level. A design with a swapped rank or a wrong offset returns the vector of the loser instead of the winner. Masked requests and the two mask inputs are applied separately. A mask wired to the wrong source lets a blocked request through, or blocks a trap, and the returned vector or the pending flag shows it. The base is moved between fetches, and a reset fetch is made afterwards: a base applied to reset vectors, or missed on other vectors, shows up in the upper byte. A peripheral request is pulled between the pending flag and the strobe. A design that latched the request at recognition would return that request's own vector instead of the spurious one.

// File: rtl/excvec_pkg.sv
package excvec_pkg;
    localparam logic [15:0] VEC_POR    = 16'hFFFE;
    localparam logic [15:0] VEC_CLKMON = 16'hFFFC;
    localparam logic [15:0] VEC_WDOG   = 16'hFFFA;
    localparam logic [7:0]  OFS_TRAP   = 8'hF8;
    localparam logic [7:0]  OFS_SWI    = 8'hF6;
    localparam logic [7:0]  OFS_X      = 8'hF4;
    localparam logic [7:0]  OFS_IRQ    = 8'hF2;
    localparam logic [7:0]  OFS_PER0   = 8'hF0;
    localparam logic [7:0]  OFS_SPUR   = 8'h80;
    localparam logic [7:0]  BASE_RST   = 8'hFF;

    typedef struct packed {
        logic [7:0]  base;
        logic [15:0] vec;
    } excvec_state_t;
endpackage

// File: rtl/excvec_per_enc.sv
module excvec_per_enc #(
    parameter int N_LINES = 56,
    localparam int IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic [N_LINES-1:0] lines,
    output logic               hit,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int n = N_LINES - 1; n >= 0; n--) begin
            if (lines[n]) begin
                hit = 1'b1;
                idx = IDX_W'(n);
            end
        end
    end
endmodule

// File: rtl/excvec_resolve.sv
module excvec_resolve
    import excvec_pkg::*;
#(
    parameter int N_PERIPH = 56
) (
    input  logic                rst_por,
    input  logic                rst_clkmon,
    input  logic                rst_wdog,
    input  logic                trap_req,
    input  logic                swi_req,
    input  logic                xreq,
    input  logic                irq_req,
    input  logic [N_PERIPH-1:0] per_req,
    input  logic                x_mask,
    input  logic                i_mask,
    input  logic [7:0]          base,
    output logic                pending,
    output logic [15:0]         vec
);
    localparam int IDX_W = (N_PERIPH > 1) ? $clog2(N_PERIPH) : 1;

    logic [N_PERIPH-1:0] per_live;
    logic                per_hit;
    logic [IDX_W-1:0]    per_idx;
    logic                x_live;
    logic                irq_live;
    logic [7:0]          per_ofs;

    assign per_live = i_mask ? '0 : per_req;
    assign x_live   = xreq & ~x_mask;
    assign irq_live = irq_req & ~i_mask;

    excvec_per_enc #(.N_LINES(N_PERIPH)) per_enc_i (
        .lines(per_live),
        .hit  (per_hit),
        .idx  (per_idx)
    );

    assign per_ofs = 8'(OFS_PER0 - (8'(per_idx) << 1));
    assign pending = trap_req | swi_req | x_live | irq_live | per_hit;

    always_comb begin
        if (rst_por)         vec = VEC_POR;
        else if (rst_clkmon) vec = VEC_CLKMON;
        else if (rst_wdog)   vec = VEC_WDOG;
        else if (trap_req)   vec = {base, OFS_TRAP};
        else if (swi_req)    vec = {base, OFS_SWI};
        else if (x_live)     vec = {base, OFS_X};
        else if (irq_live)   vec = {base, OFS_IRQ};
        else if (per_hit)    vec = {base, per_ofs};
        else                 vec = {base, OFS_SPUR};
    end
endmodule

// File: rtl/excvec_gen.sv
module excvec_gen
    import excvec_pkg::*;
#(
    parameter int N_PERIPH = 56
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rst_por,
    input  logic                rst_clkmon,
    input  logic                rst_wdog,
    input  logic                trap_req,
    input  logic                swi_req,
    input  logic                xreq,
    input  logic                irq_req,
    input  logic [N_PERIPH-1:0] per_req,
    input  logic                x_mask,
    input  logic                i_mask,
    input  logic                base_wr,
    input  logic [7:0]          base_wdata,
    input  logic                vec_req,
    output logic                int_pending,
    output logic [15:0]         vec_addr
);
    excvec_state_t st_d, st_q;
    logic [15:0]   vec_now;

    excvec_resolve #(.N_PERIPH(N_PERIPH)) resolve_i (
        .rst_por   (rst_por),
        .rst_clkmon(rst_clkmon),
        .rst_wdog  (rst_wdog),
        .trap_req  (trap_req),
        .swi_req   (swi_req),
        .xreq      (xreq),
        .irq_req   (irq_req),
        .per_req   (per_req),
        .x_mask    (x_mask),
        .i_mask    (i_mask),
        .base      (st_q.base),
        .pending   (int_pending),
        .vec       (vec_now)
    );

    always_comb begin
        st_d = st_q;
        if (base_wr) st_d.base = base_wdata;
        if (vec_req) st_d.vec  = vec_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.base <= BASE_RST;
            st_q.vec  <= VEC_POR;
        end else begin
            st_q <= st_d;
        end
    end

    assign vec_addr = st_q.vec;
endmodule

// File: rtl/excvec_chk.sv
module excvec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rst_por,
    input logic        rst_clkmon,
    input logic        rst_wdog,
    input logic        trap_req,
    input logic        swi_req,
    input logic        vec_req,
    input logic        int_pending,
    input logic [15:0] vec_addr
);
    p_por_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req && rst_por |=> vec_addr == 16'hFFFE);

    p_clkmon_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req && !rst_por && rst_clkmon |=> vec_addr == 16'hFFFC);

    p_wdog_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req && !rst_por && !rst_clkmon && rst_wdog |=> vec_addr == 16'hFFFA);

    p_trap_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req || swi_req) |-> int_pending);

    p_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req && !int_pending && !rst_por && !rst_clkmon && !rst_wdog
        |=> vec_addr[7:0] == 8'h80);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_req |=> $stable(vec_addr));

    p_even_ofs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req && !rst_por && !rst_clkmon && !rst_wdog
        |=> vec_addr[0] == 1'b0 && vec_addr[7:0] >= 8'h80 && vec_addr[7:0] <= 8'hF8);
endmodule

bind excvec_gen excvec_chk chk_i (.*);

// File: tb/excvec_gen_tb_top.sv
module excvec_gen_tb_top;
    localparam int NP = 56;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rst_por = 0, rst_clkmon = 0, rst_wdog = 0;
    logic          trap_req = 0, swi_req = 0, xreq = 0, irq_req = 0;
    logic [NP-1:0] per_req = '0;
    logic          x_mask = 0, i_mask = 0;
    logic          base_wr = 0;
    logic [7:0]    base_wdata = 0;
    logic          vec_req = 0;
    logic          int_pending;
    logic [15:0]   vec_addr;

    int checks = 0;
    int errors = 0;
    logic [7:0] base_m = 8'hFF;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    excvec_gen #(.N_PERIPH(NP)) dut_i (.*);

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_req();
        rst_por = 0; rst_clkmon = 0; rst_wdog = 0;
        trap_req = 0; swi_req = 0; xreq = 0; irq_req = 0;
        per_req = '0; x_mask = 0; i_mask = 0;
    endtask

    // driver: inputs already set at a negedge; pulse the strobe for one edge
    task automatic fetch(input logic [15:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        vec_req = 1;
        @(negedge clk);
        vec_req = 0;
        @(negedge clk);
    endtask

    task automatic write_base(input logic [7:0] b);
        base_wr = 1; base_wdata = b;
        @(negedge clk);
        base_wr = 0;
        base_m = b;
    endtask

    // monitor
    always begin
        @(posedge clk);
        if (vec_req && rst_n) begin
            #1;
            if (exp_q.size() == 0) begin
                check(0, "unexpected fetch", vec_addr, 16'h0);
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(vec_addr == e, t, vec_addr, e);
            end
        end
    end

    function automatic logic [15:0] pv(input int n);
        return {base_m, 8'(8'hF0 - 2 * n)};
    endfunction

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        check(vec_addr == 16'hFFFE, "R1 reset vec", vec_addr, 16'hFFFE);
        check(int_pending == 0, "R1/R7 pending idle", 16'(int_pending), 16'h0);
        rst_n = 1;
        @(negedge clk);
        fetch(16'hFF80, "R1/R6 reset base spurious");

        // R2 reset ordering
        clear_req(); rst_por = 1; rst_clkmon = 1; rst_wdog = 1; trap_req = 1; per_req = '1;
        fetch(16'hFFFE, "R2 por wins");
        rst_por = 0; fetch(16'hFFFC, "R2 clkmon next");
        rst_clkmon = 0; fetch(16'hFFFA, "R2 wdog next");

        // R3 ordering
        clear_req(); trap_req = 1; swi_req = 1; xreq = 1; irq_req = 1; per_req = '1;
        fetch(16'hFFF8, "R3 trap wins");
        trap_req = 0; fetch(16'hFFF6, "R3 swi next");
        swi_req = 0; fetch(16'hFFF4, "R3 x next");
        xreq = 0; fetch(16'hFFF2, "R3 irq next");
        irq_req = 0; fetch(pv(0), "R4 per0 below irq");

        // R4 peripherals
        clear_req(); per_req[9] = 1; per_req[30] = 1;
        fetch(pv(9), "R4 lower n wins");
        per_req = '0; per_req[NP-1] = 1;
        fetch(pv(NP-1), "R4 last line offset 0x82");
        per_req = '0; per_req[17] = 1;
        fetch(pv(17), "R4 single line");

        // R5 masks
        clear_req(); xreq = 1; irq_req = 1; x_mask = 1;
        fetch(16'hFFF2, "R5 x masked");
        i_mask = 1; per_req[3] = 1;
        @(negedge clk);
        check(int_pending == 0, "R5/R7 all masked pending", 16'(int_pending), 16'h0);
        fetch(16'hFF80, "R5 i mask blocks irq and per");
        trap_req = 1;
        @(negedge clk);
        check(int_pending == 1, "R5/R7 trap unmaskable pending", 16'(int_pending), 16'h1);
        fetch(16'hFFF8, "R5 trap unmaskable");
        trap_req = 0; swi_req = 1;
        fetch(16'hFFF6, "R5 swi unmaskable");
        clear_req(); xreq = 1; i_mask = 1;
        fetch(16'hFFF4, "R5 x not gated by i mask");

        // R9 base relocation
        clear_req();
        write_base(8'h3C);
        fetch(16'h3C80, "R9 spurious relocated");
        irq_req = 1; fetch(16'h3CF2, "R9 irq relocated");
        irq_req = 0; per_req[1] = 1; fetch(pv(1), "R9 per relocated");
        per_req = '0; rst_wdog = 1; fetch(16'hFFFA, "R2/R9 reset not relocated");
        rst_wdog = 0;

        // R6 withdrawn request
        clear_req(); per_req[5] = 1;
        @(negedge clk);
        check(int_pending == 1, "R7 pending on request", 16'(int_pending), 16'h1);
        per_req[5] = 0;
        @(negedge clk);
        check(int_pending == 0, "R7 pending drops", 16'(int_pending), 16'h0);
        fetch(16'h3C80, "R6 withdrawn gives spurious");

        // R8 hold
        irq_req = 1; fetch(16'h3CF2, "R8 setup");
        irq_req = 0; trap_req = 1; rst_por = 1;
        repeat (4) @(negedge clk);
        check(vec_addr == 16'h3CF2, "R8 hold without strobe", vec_addr, 16'h3CF2);
        clear_req();
        write_base(8'h01);
        check(vec_addr == 16'h3CF2, "R8/R9 base write no vec change", vec_addr, 16'h3CF2);
        fetch(16'h0180, "R9 second base");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "scoreboard drained", 16'(exp_q.size()), 16'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule